// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block turns a word-addressed virtual address into a physical address by fetching one page table entry from memory. The virtual address is cut into a virtual page number (upper field) and a page offset (lower field). The entry sits at the word address formed by adding the page number to a page-table base register. The walker reads that word through a simple read port, checks its valid and write-permission flags, and then either returns the physical address or reports a trap. The physical address is the entry's frame number followed by the unchanged offset.

A requester may ask for a second read of the data word at the translated address. In that case the data comes back with the translation, and the walk costs two memory references instead of one. Every response reports how many references it used. A trap records the faulting page number in a status output for handler logic. The base register is loaded through its own write strobe. A load that arrives during a walk is held back and applied once the walk has finished.

Top module: `pt_walker`

## Requirements
- R1: The low 12 bits of `req_vaddr` are the offset and the upper 20 bits are the virtual page number. The first read of a walk is issued at word address `base + VPN`.
- R2: On success, `rsp_paddr` holds the entry's frame number (entry bits 19:0) as its upper 20 bits and the request offset as its low 12 bits.
- R3: An entry with bit 31 (valid) clear gives `rsp_trap` = 1 (page fault), `rsp_data` = 0 and `rsp_refs` = 1, and no data read is made.
- R4: A write request to a valid entry with bit 30 (writable) clear gives `rsp_trap` = 2 (protection). An invalid entry gives code 1 even for a write. Code 0 means no trap.
- R5: With `req_fetch` set and no trap, a second read at the physical address returns its word on `rsp_data` with `rsp_refs` = 2. Without `req_fetch`, `rsp_refs` = 1.
- R6: Only one walk is outstanding at a time. `req_ready` is low from acceptance until `rsp_ack`, and all response outputs stay stable while `rsp_valid` is high and `rsp_ack` is low.
- R7: A trap loads `fault_vpn` with the request's page number. A successful walk leaves `fault_vpn` unchanged.
- R8: A base write while idle takes effect for the next walk. A base write during a walk does not affect that walk and takes effect for later walks.
- R9: After reset, `req_ready` = 1, `rsp_valid` = 0, `mem_rd_en` = 0, `rsp_trap` = 0 and `fault_vpn` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Load strobe for the page-table base |
| base_wr_data | input | 32 | New page-table base (word address) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual word address |
| req_write | input | 1 | Request is a write access |
| req_fetch | input | 1 | Also read the data word |
| mem_rd_en | output | 1 | Read request, held until `mem_rd_valid` |
| mem_addr | output | 32 | Read word address |
| mem_rd_valid | input | 1 | Read data present this cycle |
| mem_rd_data | input | 32 | Read data word |
| rsp_valid | output | 1 | Response present |
| rsp_ack | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address (0 on trap) |
| rsp_data | output | 32 | Fetched data word (0 if none) |
| rsp_trap | output | 2 | 0 none, 1 page fault, 2 protection |
| rsp_refs | output | 2 | Memory references used by this walk |
| fault_vpn | output | 20 | Page number of the last trapped request |

## Verification
The hardest case to reach from the ports is a base load that lands while a walk is waiting on memory. The bench holds the memory model's answer back by one cycle. In the cycle after a request is accepted, it pulses the base write strobe. It then checks that the in-flight walk still read its entry under the old base, and that the next walk reads under the new one. The trap priority (an invalid entry on a write) and the held response under a delayed acknowledge are driven directly.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    TRAP_NONE = 2'd0,
    TRAP_PAGE = 2'd1,
    TRAP_PROT = 2'd2
  } trap_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PTE  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } walk_st_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          busy,
  output logic [AW-1:0] base_o
);
  logic [AW-1:0] base_q, base_d, hold_q, hold_d;
  logic          pend_q, pend_d;

  always_comb begin
    base_d = base_q;
    hold_d = hold_q;
    pend_d = pend_q;
    if (!busy) begin
      pend_d = 1'b0;
      if (wr_en)       base_d = wr_data;
      else if (pend_q) base_d = hold_q;
    end else if (wr_en) begin
      pend_d = 1'b1;
      hold_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      base_q <= base_d;
      hold_q <= hold_d;
      pend_q <= pend_d;
    end
  end

  assign base_o = base_q;

  // R8: the base seen by a walk never moves while that walk is in flight
  a_r8_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(base_q));
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  logic  valid_i,
  input  logic  writable_i,
  input  logic  is_write_i,
  output trap_e trap_o
);
  // invalid entry outranks the permission check (R4)
  always_comb begin
    if (!valid_i)                      trap_o = TRAP_PAGE;
    else if (is_write_i && !writable_i) trap_o = TRAP_PROT;
    else                               trap_o = TRAP_NONE;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int FRAME_W   = 20,
  parameter int WORD_W    = 32,
  parameter int VALID_BIT = 31,
  parameter int WR_BIT    = 30
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  base_wr_en,
  input  logic [VA_W-1:0]       base_wr_data,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic                  req_write,
  input  logic                  req_fetch,
  output logic                  mem_rd_en,
  output logic [VA_W-1:0]       mem_addr,
  input  logic                  mem_rd_valid,
  input  logic [WORD_W-1:0]     mem_rd_data,
  output logic                  rsp_valid,
  input  logic                  rsp_ack,
  output logic [FRAME_W+OFF_W-1:0] rsp_paddr,
  output logic [WORD_W-1:0]     rsp_data,
  output logic [1:0]            rsp_trap,
  output logic [1:0]            rsp_refs,
  output logic [VA_W-OFF_W-1:0] fault_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PA_W  = FRAME_W + OFF_W;
  localparam int REF_W = 2;

  walk_st_e          st_q, st_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic              wr_q, wr_d, fe_q, fe_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic [WORD_W-1:0] dat_q, dat_d;
  trap_e             trap_q, trap_d, chk_trap;
  logic [REF_W-1:0]  refs_q, refs_d;
  logic [VPN_W-1:0]  fv_q, fv_d;
  logic [VA_W-1:0]   base;
  logic [VA_W-1:0]   pte_addr;
  logic              busy;

  assign busy = (st_q != ST_IDLE);

  ptw_base_reg #(.AW(VA_W)) i_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (base_wr_en),
    .wr_data (base_wr_data),
    .busy    (busy),
    .base_o  (base)
  );

  ptw_pte_check i_chk (
    .valid_i    (mem_rd_data[VALID_BIT]),
    .writable_i (mem_rd_data[WR_BIT]),
    .is_write_i (wr_q),
    .trap_o     (chk_trap)
  );

  assign pte_addr = base + VA_W'(va_q[VA_W-1:OFF_W]);

  always_comb begin
    st_d   = st_q;
    va_d   = va_q;
    wr_d   = wr_q;
    fe_d   = fe_q;
    pa_d   = pa_q;
    dat_d  = dat_q;
    trap_d = trap_q;
    refs_d = refs_q;
    fv_d   = fv_q;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        va_d   = req_vaddr;
        wr_d   = req_write;
        fe_d   = req_fetch;
        pa_d   = '0;
        dat_d  = '0;
        trap_d = TRAP_NONE;
        refs_d = '0;
        st_d   = ST_PTE;
      end
      ST_PTE: if (mem_rd_valid) begin
        refs_d = refs_q + 1'b1;
        trap_d = chk_trap;
        if (chk_trap != TRAP_NONE) begin
          fv_d = va_q[VA_W-1:OFF_W];
          st_d = ST_DONE;
        end else begin
          pa_d = {mem_rd_data[FRAME_W-1:0], va_q[OFF_W-1:0]};
          st_d = fe_q ? ST_DATA : ST_DONE;
        end
      end
      ST_DATA: if (mem_rd_valid) begin
        refs_d = refs_q + 1'b1;
        dat_d  = mem_rd_data;
        st_d   = ST_DONE;
      end
      ST_DONE: if (rsp_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      wr_q   <= 1'b0;
      fe_q   <= 1'b0;
      pa_q   <= '0;
      dat_q  <= '0;
      trap_q <= TRAP_NONE;
      refs_q <= '0;
      fv_q   <= '0;
    end else begin
      st_q   <= st_d;
      va_q   <= va_d;
      wr_q   <= wr_d;
      fe_q   <= fe_d;
      pa_q   <= pa_d;
      dat_q  <= dat_d;
      trap_q <= trap_d;
      refs_q <= refs_d;
      fv_q   <= fv_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign rsp_valid = (st_q == ST_DONE);
  assign mem_rd_en = (st_q == ST_PTE) || (st_q == ST_DATA);
  assign mem_addr  = (st_q == ST_DATA) ? VA_W'(pa_q) : pte_addr;
  assign rsp_paddr = pa_q;
  assign rsp_data  = dat_q;
  assign rsp_trap  = trap_q;
  assign rsp_refs  = refs_q;
  assign fault_vpn = fv_q;

  // R6: a pending response blocks new requests
  a_r6_one_walk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R6: response held until acknowledged
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ack) |=> (rsp_valid && $stable(rsp_paddr) &&
      $stable(rsp_data) && $stable(rsp_trap) && $stable(rsp_refs)));

  // R6: a read request keeps its address until answered
  a_r6_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_rd_valid) |=> (mem_rd_en && $stable(mem_addr)));

  // R3: a trapped walk used only the entry read
  a_r3_trap_one_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_trap != 2'd0) |-> (rsp_refs == 2'd1 && rsp_data == '0));

  // R5: a finished walk used one or two references
  a_r5_refs_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_refs == 2'd1 || rsp_refs == 2'd2));
endmodule

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic        req_valid, req_ready, req_write, req_fetch;
  logic [31:0] req_vaddr;
  logic        mem_rd_en, mem_rd_valid;
  logic [31:0] mem_addr, mem_rd_data;
  logic        rsp_valid, rsp_ack;
  logic [31:0] rsp_paddr, rsp_data;
  logic [1:0]  rsp_trap, rsp_refs;
  logic [19:0] fault_vpn;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_fetch(req_fetch),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_paddr(rsp_paddr),
    .rsp_data(rsp_data), .rsp_trap(rsp_trap), .rsp_refs(rsp_refs),
    .fault_vpn(fault_vpn)
  );

  // entry format: bit31 valid, bit30 writable, bits19:0 frame
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    if (a < 32'h1000) begin
      case (a)
        32'h110: return 32'h8000_0022;
        32'h111: return 32'hC000_0045;
        32'h112: return 32'h0000_0078;
        32'h210: return 32'hC000_0099;
        default: return 32'h0;
      endcase
    end
    return a ^ 32'hA5A5_0000;
  endfunction

  // memory answers one cycle after the request is seen
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rd_valid <= 1'b0;
      mem_rd_data  <= '0;
    end else begin
      mem_rd_valid <= mem_rd_en && !mem_rd_valid;
      mem_rd_data  <= mem_word(mem_addr);
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  logic [31:0] first_addr;

  task automatic start_req(input logic [31:0] va, input logic wr, input logic fe);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_fetch = fe;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp();
    bit got = 0;
    first_addr = 32'hFFFF_FFFF;
    for (int i = 0; i < 50 && !got; i++) begin
      if (mem_rd_en && first_addr == 32'hFFFF_FFFF) first_addr = mem_addr;
      if (rsp_valid) got = 1;
      else @(negedge clk);
    end
  endtask

  task automatic ack();
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
  endtask

  // {vaddr, write, fetch, trap, paddr, refs}
  localparam logic [69:0] VEC [7] = '{
    {32'h0001_0020, 1'b0, 1'b1, 2'd0, 32'h0002_2020, 2'd2},
    {32'h0001_0020, 1'b0, 1'b0, 2'd0, 32'h0002_2020, 2'd1},
    {32'h0001_0020, 1'b1, 1'b1, 2'd2, 32'h0000_0000, 2'd1},
    {32'h0001_1ABC, 1'b1, 1'b1, 2'd0, 32'h0004_5ABC, 2'd2},
    {32'h0001_2000, 1'b0, 1'b1, 2'd1, 32'h0000_0000, 2'd1},
    {32'h0001_2FFF, 1'b1, 1'b1, 2'd1, 32'h0000_0000, 2'd1},
    {32'h0001_1FFF, 1'b0, 1'b0, 2'd0, 32'h0004_5FFF, 2'd1}
  };

  initial begin
    logic [19:0] exp_fv;
    rst_n = 1'b0; base_wr_en = 0; base_wr_data = 0;
    req_valid = 0; req_vaddr = 0; req_write = 0; req_fetch = 0; rsp_ack = 0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 req_ready", 32'(req_ready), 32'd1);
    chk("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9 mem_rd_en", 32'(mem_rd_en), 32'd0);
    chk("R9 rsp_trap", 32'(rsp_trap), 32'd0);
    chk("R9 fault_vpn", 32'(fault_vpn), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    base_wr_en = 1; base_wr_data = 32'h100;
    @(negedge clk);
    base_wr_en = 0;
    exp_fv = '0;

    for (int k = 0; k < 7; k++) begin
      logic [69:0] v;
      v = VEC[k];
      start_req(v[69:38], v[37], v[36]);
      wait_rsp();
      chk("R6 rsp_valid", 32'(rsp_valid), 32'd1);
      chk("R1 pte address", first_addr, 32'h100 + 32'(v[69:50]));
      chk("R3/R4 trap", 32'(rsp_trap), 32'(v[35:34]));
      chk("R5 refs", 32'(rsp_refs), 32'(v[1:0]));
      chk("R2 paddr", rsp_paddr, v[33:2]);
      chk("R5 data", rsp_data,
          (v[35:34] == 2'd0 && v[36]) ? mem_word(v[33:2]) : 32'h0);
      if (v[35:34] != 2'd0) exp_fv = v[69:50];
      chk("R7 fault_vpn", 32'(fault_vpn), 32'(exp_fv));
      ack();
    end

    // R6 hold under delayed acknowledge
    start_req(32'h0001_1004, 1'b0, 1'b1);
    wait_rsp();
    repeat (4) @(negedge clk);
    chk("R6 held valid", 32'(rsp_valid), 32'd1);
    chk("R6 ready low", 32'(req_ready), 32'd0);
    chk("R6 held paddr", rsp_paddr, 32'h0004_5004);
    ack();
    chk("R6 ready after ack", 32'(req_ready), 32'd1);

    // R8 base write during a walk is deferred
    @(negedge clk);
    req_valid = 1; req_vaddr = 32'h0001_0020; req_write = 0; req_fetch = 0;
    @(negedge clk);
    req_valid = 0;
    chk("R8 walk busy", 32'(mem_rd_en), 32'd1);
    chk("R8 old base addr", mem_addr, 32'h110);
    base_wr_en = 1; base_wr_data = 32'h200;
    @(negedge clk);
    base_wr_en = 0;
    wait_rsp();
    chk("R8 old base paddr", rsp_paddr, 32'h0002_2020);
    ack();
    start_req(32'h0001_0020, 1'b1, 1'b1);
    wait_rsp();
    chk("R8 new base addr", first_addr, 32'h210);
    chk("R8 new base paddr", rsp_paddr, 32'h0009_9020);
    chk("R8 new base trap", 32'(rsp_trap), 32'd0);
    ack();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule